// File: doc/BRIEF.md
# Slot-Scheduled Ring Switch Controller

This block sets the resonance control bits of a five-port optical circuit switch from a fixed, repeating time-division schedule. The ports are north, south, east, west and a local port toward the node's gateway. A schedule table has one entry per time slot. Each entry holds twelve ring-enable bits, one for each microring. While the block runs, a slot counter steps once per pulse of the TDM slot tick. The entry for the new slot goes onto the ring outputs at that same clock edge, so every ring changes together at the slot boundary. After the last active slot the counter returns to slot 0, and the same frame plays again unchanged.

Software, or a boot sequencer, fills the table while the block is stopped. It writes one entry at a time as a 16-bit turn request, with one bit per possible turning path through the switch. The switch routes dimension-ordered (X first, then Y). A packet travelling in Y (entering from north or south) may therefore never turn into X (leaving east or west). Writes that ask for such a turn are refused and raise a sticky error flag. The number of active slots is also set while stopped. While stopped, every ring is held off-resonance. A start pulse begins playback at slot 0, and a halt pulse returns to the stopped state.

Top module: `tdm_ring_ctrl`

## Requirements
- R1: After reset the block is stopped (`sched_running`=0), `ring_on`=0, `slot_idx`=0, `turn_err`=0, and the active slot count equals MAX_SLOTS (16 by default).
- R2: While stopped, `ring_on` stays all-zero whatever the table holds and whatever `tdm_tick` does, and `slot_idx` stays 0.
- R3: A `sched_start` pulse while stopped makes the block running from the next cycle, with `slot_idx`=0 and `ring_on` equal to the ring bits of entry 0.
- R4: While running, each `tdm_tick` cycle moves `slot_idx` to the next slot, and `ring_on` takes that slot's entry at the same edge with all bits together. In a cycle without a tick, both hold.
- R5: The slot index wraps from (active count − 1) to 0. `len_we` with `len_val` from 1 to MAX_SLOTS, while stopped, sets the active count. The values 0 and anything above MAX_SLOTS are ignored. An active count of 1 keeps the slot at 0.
- R6: Turn request bit encoding is 0 E→N, 1 E→S, 2 E→local, 3 W→N, 4 W→S, 5 W→local, 6 N→local, 7 S→local, 8 local→N, 9 local→S, 10 local→E, 11 local→W, 12 N→E, 13 N→W, 14 S→E, 15 S→W. Ring k is driven by request bit k (k = 0 to 11).
- R7: A table write while stopped that has any of request bits 15..12 set leaves the entry unchanged and sets `turn_err`. Only reset clears `turn_err`.
- R8: Table writes and slot-count writes made while running have no effect.
- R9: A `sched_halt` pulse while running stops the block from the next cycle, with `ring_on`=0 and `slot_idx`=0. Halt takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| tdm_tick | input | 1 | One-cycle pulse marking a slot boundary |
| sched_start | input | 1 | Begin schedule playback at slot 0 |
| sched_halt | input | 1 | Stop playback and darken rings |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | SLOT_W (4) | Slot entry to write |
| tbl_turns | input | 16 | Turn request word for that slot |
| len_we | input | 1 | Active slot count write strobe |
| len_val | input | LEN_W (5) | Active slot count, 1..MAX_SLOTS |
| ring_on | output | 12 | Ring resonance enables, one per ring |
| slot_idx | output | SLOT_W (4) | Current slot |
| sched_running | output | 1 | Playback active |
| turn_err | output | 1 | Sticky flag: a forbidden-turn write was refused |

## Verification
The bench fills the table with distinct patterns and runs the schedule across several frames. It checks the outputs after every tick against its own model. A counter that wrapped one slot early or late, or that ignored the programmed count, would show the wrong slot number and ring word at the wrap. Tick-free gaps and idle ticks are also driven. A design that let rings light while stopped, or drifted without a tick, would show nonzero or shifting outputs there. The bench writes entries and slot counts during playback, writes forbidden turns, and sends halt together with a tick. A design that took those writes would replay altered entries or a different frame length. One that accepted a forbidden turn would show the new ring word once it reached that slot. One that let the tick win would stay running.

// File: rtl/tdm_ring_pkg.sv
package tdm_ring_pkg;

    // twelve microrings, sixteen turning paths through a five-port switch
    localparam int unsigned RING_W = 12;
    localparam int unsigned TURN_W = 16;

    // request bits at or above this index name Y-to-X turns
    localparam int unsigned FORBID_LO = RING_W;

    typedef enum logic {
        CTL_LOAD = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_mode_e;

endpackage

// File: rtl/tdm_turn_filter.sv
module tdm_turn_filter
    import tdm_ring_pkg::*;
(
    input  logic [TURN_W-1:0] turns,
    output logic              legal,
    output logic [RING_W-1:0] ring_bits
);

    // every legal path has its own ring at the same bit position
    for (genvar g = 0; g < RING_W; g++) begin : g_map
        assign ring_bits[g] = turns[g];
    end

    // Y-to-X turns have no ring; any request for them is illegal
    assign legal = ~|turns[TURN_W-1:FORBID_LO];

endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned LEN_W  = 5
) (
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [LEN_W-1:0]  act_len,
    output logic [SLOT_W-1:0] nxt_slot
);

    logic [LEN_W-1:0] inc;

    always_comb begin
        inc = LEN_W'(cur_slot) + LEN_W'(1);
        if (inc >= act_len) begin
            nxt_slot = '0;
        end else begin
            nxt_slot = inc[SLOT_W-1:0];
        end
    end

endmodule

// File: rtl/tdm_sched_table.sv
module tdm_sched_table #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WIDTH  = 12,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en && (int'(wr_addr) < int'(DEPTH))) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_addr) < int'(DEPTH)) begin
            rd_data = mem_q[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/tdm_ring_ctrl.sv
module tdm_ring_ctrl #(
    parameter  int unsigned MAX_SLOTS = 16,
    localparam int unsigned SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int unsigned LEN_W     = $clog2(MAX_SLOTS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tdm_tick,
    input  logic                             sched_start,
    input  logic                             sched_halt,
    input  logic                             tbl_we,
    input  logic [SLOT_W-1:0]                tbl_addr,
    input  logic [tdm_ring_pkg::TURN_W-1:0]  tbl_turns,
    input  logic                             len_we,
    input  logic [LEN_W-1:0]                 len_val,
    output logic [tdm_ring_pkg::RING_W-1:0]  ring_on,
    output logic [SLOT_W-1:0]                slot_idx,
    output logic                             sched_running,
    output logic                             turn_err
);
    import tdm_ring_pkg::*;

    typedef struct packed {
        ctl_mode_e         mode;
        logic [SLOT_W-1:0] slot;
        logic [LEN_W-1:0]  len;
        logic [RING_W-1:0] ring;
        logic              err;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    logic              idle_q;
    logic              cfg_open;
    logic              req_legal;
    logic [RING_W-1:0] req_ring;
    logic              tbl_wr_ok;
    logic [SLOT_W-1:0] nxt_slot;
    logic [SLOT_W-1:0] rd_addr;
    logic [RING_W-1:0] rd_ring;
    logic              len_ok;

    assign idle_q   = (state_q.mode == CTL_LOAD);
    // configuration is accepted only while stopped and not starting
    assign cfg_open = idle_q && !sched_start;

    tdm_turn_filter u_filter (
        .turns     (tbl_turns),
        .legal     (req_legal),
        .ring_bits (req_ring)
    );

    tdm_slot_counter #(
        .SLOT_W (SLOT_W),
        .LEN_W  (LEN_W)
    ) u_counter (
        .cur_slot (state_q.slot),
        .act_len  (state_q.len),
        .nxt_slot (nxt_slot)
    );

    assign tbl_wr_ok = tbl_we && cfg_open && req_legal;
    // stopped: look at slot 0 for the coming start; running: the next slot
    assign rd_addr   = idle_q ? '0 : nxt_slot;

    tdm_sched_table #(
        .DEPTH  (MAX_SLOTS),
        .WIDTH  (RING_W),
        .ADDR_W (SLOT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_ok),
        .wr_addr (tbl_addr),
        .wr_data (req_ring),
        .rd_addr (rd_addr),
        .rd_data (rd_ring)
    );

    assign len_ok = (len_val != '0) && (len_val <= LEN_W'(MAX_SLOTS));

    always_comb begin
        state_d = state_q;

        if (tbl_we && cfg_open && !req_legal) begin
            state_d.err = 1'b1;
        end
        if (len_we && cfg_open && len_ok) begin
            state_d.len = len_val;
        end

        unique case (state_q.mode)
            CTL_LOAD: begin
                state_d.slot = '0;
                state_d.ring = '0;
                if (sched_start) begin
                    state_d.mode = CTL_RUN;
                    state_d.ring = rd_ring;
                end
            end
            CTL_RUN: begin
                if (sched_halt) begin
                    state_d.mode = CTL_LOAD;
                    state_d.slot = '0;
                    state_d.ring = '0;
                end else if (tdm_tick) begin
                    state_d.slot = nxt_slot;
                    state_d.ring = rd_ring;
                end
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode <= CTL_LOAD;
            state_q.slot <= '0;
            state_q.len  <= LEN_W'(MAX_SLOTS);
            state_q.ring <= '0;
            state_q.err  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ring_on       = state_q.ring;
    assign slot_idx      = state_q.slot;
    assign sched_running = (state_q.mode == CTL_RUN);
    assign turn_err      = state_q.err;

endmodule

// File: rtl/tdm_ring_ctrl_chk.sv
module tdm_ring_ctrl_chk #(
    parameter  int unsigned MAX_SLOTS = 16,
    localparam int unsigned SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int unsigned LEN_W     = $clog2(MAX_SLOTS + 1)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            tdm_tick,
    input logic                            sched_start,
    input logic                            sched_halt,
    input logic                            tbl_we,
    input logic [3:0]                      forbid_bits,
    input logic [tdm_ring_pkg::RING_W-1:0] ring_on,
    input logic [SLOT_W-1:0]               slot_idx,
    input logic                            sched_running,
    input logic                            turn_err,
    input logic [LEN_W-1:0]                act_len
);

    // R2
    dark_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_running |-> (ring_on == '0 && slot_idx == '0));

    // R3
    start_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_running && sched_start) |=> (sched_running && slot_idx == '0));

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_running && !tdm_tick && !sched_halt) |=>
            ($stable(slot_idx) && $stable(ring_on)));

    // R5
    slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(slot_idx) < act_len);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_err |=> turn_err);

    // R7
    reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_running && !sched_start && tbl_we && (forbid_bits != '0)) |=> turn_err);

    // R8
    len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_running && !sched_halt) |=> $stable(act_len));

    // R9
    halt_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_running && sched_halt) |=>
            (!sched_running && ring_on == '0 && slot_idx == '0));

endmodule

bind tdm_ring_ctrl tdm_ring_ctrl_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tdm_tick      (tdm_tick),
    .sched_start   (sched_start),
    .sched_halt    (sched_halt),
    .tbl_we        (tbl_we),
    .forbid_bits   (tbl_turns[15:12]),
    .ring_on       (ring_on),
    .slot_idx      (slot_idx),
    .sched_running (sched_running),
    .turn_err      (turn_err),
    .act_len       (state_q.len)
);

// File: tb/tb_tdm_ring_ctrl.sv
module tb_tdm_ring_ctrl;

    localparam int MAX = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdm_tick = 1'b0;
    logic        sched_start = 1'b0;
    logic        sched_halt = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [15:0] tbl_turns = '0;
    logic        len_we = 1'b0;
    logic [4:0]  len_val = '0;
    logic [11:0] ring_on;
    logic [3:0]  slot_idx;
    logic        sched_running;
    logic        turn_err;

    always #10 clk = ~clk;

    tdm_ring_ctrl #(.MAX_SLOTS(MAX)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tdm_tick      (tdm_tick),
        .sched_start   (sched_start),
        .sched_halt    (sched_halt),
        .tbl_we        (tbl_we),
        .tbl_addr      (tbl_addr),
        .tbl_turns     (tbl_turns),
        .len_we        (len_we),
        .len_val       (len_val),
        .ring_on       (ring_on),
        .slot_idx      (slot_idx),
        .sched_running (sched_running),
        .turn_err      (turn_err)
    );

    // bench model, built from the requirements
    logic [11:0] m_tab [MAX];
    int          m_len = MAX;
    int          m_slot = 0;
    bit          m_run = 1'b0;
    bit          m_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " ring_on"}, int'(ring_on), m_run ? int'(m_tab[m_slot]) : 0);
        chk({req, " slot_idx"}, int'(slot_idx), m_slot);
        chk({req, " running"}, int'(sched_running), int'(m_run));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic do_write(input int addr, input logic [15:0] turns);
        tbl_we = 1'b1; tbl_addr = 4'(addr); tbl_turns = turns;
        @(negedge clk);
        tbl_we = 1'b0; tbl_turns = '0;
        if (!m_run) begin
            if (turns[15:12] == 4'b0) m_tab[addr] = turns[11:0];
            else m_err = 1'b1;
        end
    endtask

    task automatic do_len(input int v);
        len_we = 1'b1; len_val = 5'(v);
        @(negedge clk);
        len_we = 1'b0;
        if (!m_run && v >= 1 && v <= MAX) m_len = v;
    endtask

    task automatic do_start();
        sched_start = 1'b1;
        @(negedge clk);
        sched_start = 1'b0;
        if (!m_run) begin m_run = 1'b1; m_slot = 0; end
    endtask

    task automatic do_tick();
        tdm_tick = 1'b1;
        @(negedge clk);
        tdm_tick = 1'b0;
        if (m_run) m_slot = (m_slot + 1 == m_len) ? 0 : m_slot + 1;
    endtask

    task automatic do_halt();
        sched_halt = 1'b1;
        @(negedge clk);
        sched_halt = 1'b0;
        m_run = 1'b0; m_slot = 0;
    endtask

    task automatic t_reset();
        chk_outputs("R1 reset");
        chk("R1 turn_err", int'(turn_err), 0);
    endtask

    task automatic t_default_len();
        do_start();
        for (int i = 0; i < MAX - 1; i++) do_tick();
        chk("R1 default count slot", int'(slot_idx), MAX - 1);
        do_tick();
        chk("R5 default wrap slot", int'(slot_idx), 0);
        do_halt();
        chk_outputs("R9 halt");
    endtask

    task automatic t_idle_dark();
        do_write(0, 16'h0001);
        do_write(1, 16'h0800);
        do_write(2, 16'h0FFF);
        do_write(3, 16'h05A5);
        do_write(4, 16'h03C0);
        for (int i = 0; i < 3; i++) do_tick();
        chk_outputs("R2 idle ticks");
    endtask

    task automatic t_run_len5();
        do_len(0);
        do_len(17);
        do_len(5);
        do_start();
        chk_outputs("R3 start");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_outputs("R4 hold without tick");
        end
        for (int i = 0; i < 12; i++) begin
            do_tick();
            chk_outputs("R5 R4 tick");
        end
        // entry 1 held only L->W, ring 11
        chk("R6 L->W ring bit", int'(m_tab[1][11]), 1);
    endtask

    task automatic t_run_ignore();
        // still running from the previous task
        do_write(1, 16'h0F0F);
        do_len(2);
        for (int i = 0; i < 6; i++) begin
            do_tick();
            chk_outputs("R8 write while running");
        end
        do_halt();
        chk_outputs("R9 halt after run");
    endtask

    task automatic t_encoding();
        do_write(5, 16'h0A5C);
        do_len(6);
        do_start();
        for (int i = 0; i < 5; i++) do_tick();
        chk("R6 ring word", int'(ring_on), 'h0A5C);
        do_halt();
    endtask

    task automatic t_reject();
        do_write(2, 16'h1001);
        chk("R7 err set", int'(turn_err), 1);
        do_write(3, 16'h8000);
        do_start();
        do_tick();
        do_tick();
        chk("R7 entry 2 kept", int'(ring_on), 'h0FFF);
        do_tick();
        chk("R7 entry 3 kept", int'(ring_on), 'h05A5);
        do_halt();
        do_write(6, 16'h0003);
        chk("R7 err sticky", int'(turn_err), 1);
    endtask

    task automatic t_len1();
        do_len(1);
        do_start();
        for (int i = 0; i < 3; i++) begin
            do_tick();
            chk_outputs("R5 count of one");
        end
    endtask

    task automatic t_halt_priority();
        // running from t_len1
        tdm_tick = 1'b1; sched_halt = 1'b1;
        @(negedge clk);
        tdm_tick = 1'b0; sched_halt = 1'b0;
        m_run = 1'b0; m_slot = 0;
        chk_outputs("R9 halt beats tick");
    endtask

    initial begin
        for (int i = 0; i < MAX; i++) m_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_len();
        t_idle_dark();
        t_run_len5();
        t_run_ignore();
        t_encoding();
        t_reject();
        t_len1();
        t_halt_priority();
        chk("R7 err model", int'(turn_err), int'(m_err));
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule